// File: doc/BRIEF.md
# Queued SPI Master Engine

This block is an SPI master fed from a four-entry command queue. Each 32-bit command word holds one frame of transmit data together with its own control bits: which chip selects to drive, which of four timing/format attribute sets to use, whether the chip select stays asserted into the next frame, whether this frame ends the queue, and whether the frame counter restarts. While a frame is shifted out on the serial data output, the bits arriving on the serial data input are gathered into a second four-entry queue, from which they are popped as right-aligned 16-bit values.

The serial clock is paced by an external strobe, `tick`: every strobe advances the engine by one half period of the serial clock. Software pushes command words, pops received words, flushes either queue through a control write, and clears status flags by writing ones. A 16-bit wrapping counter tracks finished frames, and a single interrupt line combines the enabled flags.

Top module: `qspi_engine`

## Requirements
- R1: A pushed command word is decoded as data in bits 15:0, a chip-select mask in bits 21:16, an attribute-set index in bits 29:28, counter clear in bit 26, end-of-queue in bit 27 and continuous select in bit 31. The index picks 7 bits of `cfg_attr` starting at bit 7*index, laid out as {lsb_first[6], cpha[5], cpol[4], length_minus_one[3:0]}.
- R2: A frame carries length_minus_one+1 bits (4 to 16), most significant bit first unless lsb_first is set. The serial clock idles at cpol; with cpha=0 the input is sampled on the first, third, ... edges, with cpha=1 on the second, fourth, ... edges. Each half period waits for one `tick`.
- R3: `cs_n` equals the idle-level register XOR the active chip-select mask. After a frame with bit 31 clear the mask is released; with bit 31 set it stays driven until a later frame releases it.
- R4: When a frame with bit 27 set finishes, status bit 28 is set and no further command starts until that bit is cleared.
- R5: Status bit 31 is set after every finished frame. Writing a one to a status bit through `stat_wr` clears it; a flag set in the same cycle wins.
- R6: Received frames are popped in arrival order as 16-bit values, right-aligned, upper bits zero; the receive queue holds four entries and `pop_empty` marks it empty.
- R7: `frame_count` increments by one per finished frame and wraps from 65535 to 0; a frame with bit 26 set first clears it, so it reads 1 afterwards.
- R8: The transmit queue holds four commands; `push_full` is high when full, and a push while full is ignored.
- R9: When a frame finishes while the receive queue is full, that frame's data is dropped and status bit 19 is set.
- R10: A control write with bit 11 set flushes the transmit queue, with bit 10 set flushes the receive queue; bits 21:16 of every control write set the idle level of each chip select (reset value all ones).
- R11: `irq` is high when status bit 31 is set with `ien_done` high, or status bit 28 is set with `ien_eoq` high.
- R12: After reset all flags are clear, both queues are empty, the counter is zero, `cs_n` is all ones and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| push_wr | input | 1 | Push command word |
| push_word | input | 32 | Command word |
| push_full | output | 1 | Transmit queue full |
| pop_rd | input | 1 | Pop received word |
| pop_data | output | 16 | Head of receive queue, right-aligned |
| pop_empty | output | 1 | Receive queue empty |
| ctl_wr | input | 1 | Control write strobe |
| ctl_word | input | 32 | Control word (flushes, idle levels) |
| stat_wr | input | 1 | Status write-one-to-clear strobe |
| stat_word | input | 32 | Bits to clear |
| status | output | 32 | Flags: 31 done, 28 end of queue, 19 overflow |
| ien_done | input | 1 | Interrupt enable for frame done |
| ien_eoq | input | 1 | Interrupt enable for end of queue |
| irq | output | 1 | Interrupt |
| cfg_attr | input | 28 | Four attribute sets of 7 bits |
| frame_count | output | 16 | Wrapping frame counter |
| tick | input | 1 | Half-period timing strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Chip-select lines |

## Verification
A queued command reaches the wire no earlier than two cycles after its push (queue write, then start), and a frame spends one tick in setup, two ticks per bit and one tick in hold before its flags, counter and received word update together one cycle after the final hold tick. The bench never counts these cycles for the serial data: a monitor follows every `sck` transition at the falling clock edge, checks the bit on `mosi` at each sampling edge and supplies `miso` from a scoreboard entry. Flag, counter and chip-select checks are taken only after the scoreboard has drained plus a margin of ten cycles, or after polling for the flag itself, so they never depend on the exact cycle of the update.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int DATA_W = 16;
  localparam int CS_W   = 6;
  localparam int ATTR_N = 4;
  localparam int SEL_W  = $clog2(ATTR_N);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int EDGE_W = IDX_W + 1;

  typedef struct packed {
    logic             lsb;
    logic             cpha;
    logic             cpol;
    logic [IDX_W-1:0] len_m1;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  typedef struct packed {
    logic              cont;
    logic [SEL_W-1:0]  attr;
    logic              eoq;
    logic              cclr;
    logic [CS_W-1:0]   cs;
    logic [DATA_W-1:0] data;
  } cmd_t;

  // Position in the data word of the idx-th bit on the wire.
  function automatic logic [IDX_W-1:0] wire_pos(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] len_m1,
                                                input logic lsb);
    return lsb ? idx : (len_m1 - idx);
  endfunction

  // Index of the bit driven after a given number of clock edges.
  function automatic logic [IDX_W-1:0] drive_index(input logic [EDGE_W-1:0] edges,
                                                   input logic cpha);
    logic [EDGE_W-1:0] e;
    e = (cpha && edges != '0) ? edges - 1'b1 : edges;
    return e[EDGE_W-1:1];
  endfunction
endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
  import qspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  attr_t             attr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data
);
  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER, S_TRAIL} st_t;

  st_t               st;
  attr_t             attr_q;
  logic [DATA_W-1:0] data_q;
  logic [EDGE_W-1:0] edges;
  logic              last_edge;
  logic              sample_now;

  assign last_edge  = (edges == {attr_q.len_m1, 1'b1});
  assign sample_now = (edges[0] == attr_q.cpha);
  assign busy       = (st != S_IDLE);
  assign mosi       = (st == S_IDLE) ? 1'b0 :
                      data_q[wire_pos(drive_index(edges, attr_q.cpha), attr_q.len_m1, attr_q.lsb)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      attr_q  <= '0;
      data_q  <= '0;
      edges   <= '0;
      sck     <= 1'b0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          attr_q  <= attr_in;
          data_q  <= data_in;
          edges   <= '0;
          sck     <= attr_in.cpol;
          rx_data <= '0;
          st      <= S_LEAD;
        end
        S_LEAD: if (tick) st <= S_XFER;
        S_XFER: if (tick) begin
          sck <= ~sck;
          if (sample_now)
            rx_data[wire_pos(edges[EDGE_W-1:1], attr_q.len_m1, attr_q.lsb)] <= miso;
          if (last_edge) st <= S_TRAIL;
          else           edges <= edges + 1'b1;
        end
        S_TRAIL: if (tick) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
  import qspi_pkg::*;
#(
  parameter int TXQ_DEPTH = 4,
  parameter int RXQ_DEPTH = 4,
  parameter int CNT_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_wr,
  input  logic [31:0]              push_word,
  output logic                     push_full,
  input  logic                     pop_rd,
  output logic [DATA_W-1:0]        pop_data,
  output logic                     pop_empty,
  input  logic                     ctl_wr,
  input  logic [31:0]              ctl_word,
  input  logic                     stat_wr,
  input  logic [31:0]              stat_word,
  output logic [31:0]              status,
  input  logic                     ien_done,
  input  logic                     ien_eoq,
  output logic                     irq,
  input  logic [ATTR_N*ATTR_W-1:0] cfg_attr,
  output logic [CNT_W-1:0]         frame_count,
  input  logic                     tick,
  output logic                     sck,
  output logic                     mosi,
  input  logic                     miso,
  output logic [CS_W-1:0]          cs_n
);
  cmd_t              cmd_in, tx_head;
  attr_t             attr_tab [ATTR_N];
  logic              tx_empty, rx_full, rx_empty;
  logic              flush_tx, flush_rx;
  logic              busy, frame_done, frame_start, rx_push;
  logic [DATA_W-1:0] rx_word, rx_head;
  logic [CS_W-1:0]   idle_lvl, cs_sel;
  logic              cur_cont, cur_eoq, cur_cclr;
  logic              stat_tc, stat_eoq, stat_ovf;
  logic              clr_tc, clr_eoq, clr_ovf;
  logic              sig_unused;

  assign sig_unused = ^{push_word[30], push_word[25:22], ctl_word[31:22], ctl_word[15:12],
                        ctl_word[9:0], stat_word[30:29], stat_word[27:20], stat_word[18:0]};

  // Command field decode (R1)
  assign cmd_in.cont = push_word[31];
  assign cmd_in.attr = push_word[29:28];
  assign cmd_in.eoq  = push_word[27];
  assign cmd_in.cclr = push_word[26];
  assign cmd_in.cs   = push_word[21:16];
  assign cmd_in.data = push_word[15:0];

  for (genvar g = 0; g < ATTR_N; g++) begin : g_attr
    assign attr_tab[g] = attr_t'(cfg_attr[g*ATTR_W +: ATTR_W]);
  end

  assign flush_tx    = ctl_wr && ctl_word[11];
  assign flush_rx    = ctl_wr && ctl_word[10];
  assign frame_start = !busy && !frame_done && !tx_empty && !stat_eoq && !flush_tx;
  assign rx_push     = frame_done && !rx_full;
  assign clr_tc      = stat_wr && stat_word[31];
  assign clr_eoq     = stat_wr && stat_word[28];
  assign clr_ovf     = stat_wr && stat_word[19];

  qspi_fifo #(.W($bits(cmd_t)), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(push_wr), .din(cmd_in),
    .pop(frame_start), .dout(tx_head), .full(push_full), .empty(tx_empty)
  );

  qspi_fifo #(.W(DATA_W), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx), .push(rx_push), .din(rx_word),
    .pop(pop_rd), .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );

  qspi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(frame_start),
    .attr_in(attr_tab[tx_head.attr]), .data_in(tx_head.data), .miso(miso),
    .busy(busy), .done(frame_done), .sck(sck), .mosi(mosi), .rx_data(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_lvl    <= '1;
      cs_sel      <= '0;
      cur_cont    <= 1'b0;
      cur_eoq     <= 1'b0;
      cur_cclr    <= 1'b0;
      frame_count <= '0;
      stat_tc     <= 1'b0;
      stat_eoq    <= 1'b0;
      stat_ovf    <= 1'b0;
    end else begin
      if (ctl_wr) idle_lvl <= ctl_word[21:16];
      if (frame_start) begin
        cs_sel   <= tx_head.cs;
        cur_cont <= tx_head.cont;
        cur_eoq  <= tx_head.eoq;
        cur_cclr <= tx_head.cclr;
      end else if (frame_done) begin
        if (!cur_cont) cs_sel <= '0;
        frame_count <= (cur_cclr ? '0 : frame_count) + 1'b1;
      end
      stat_tc  <= (stat_tc && !clr_tc) || frame_done;
      stat_eoq <= (stat_eoq && !clr_eoq) || (frame_done && cur_eoq);
      stat_ovf <= (stat_ovf && !clr_ovf) || (frame_done && rx_full);
    end
  end

  assign cs_n      = idle_lvl ^ cs_sel;
  assign pop_data  = rx_empty ? '0 : rx_head;
  assign pop_empty = rx_empty;
  assign status    = {stat_tc, 2'b00, stat_eoq, 8'h00, stat_ovf, 19'h0};
  assign irq       = (stat_tc && ien_done) || (stat_eoq && ien_eoq);
endmodule

// File: rtl/qspi_engine_chk.sv
module qspi_engine_chk #(
  parameter int CNT_W = 16,
  parameter int CS_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             frame_done,
  input logic             cur_cont,
  input logic             cur_cclr,
  input logic             stat_tc,
  input logic             stat_eoq,
  input logic             stat_ovf,
  input logic             rx_full,
  input logic [CNT_W-1:0] frame_count,
  input logic [CS_W-1:0]  cs_n,
  input logic [CS_W-1:0]  idle_lvl
);
  AST_DONE_SETS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> stat_tc); // R5
  AST_EOQ_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_eoq |-> !frame_start); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cur_cclr) |=> frame_count == CNT_W'($past(frame_count) + 1'b1)); // R7
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cur_cclr) |=> frame_count == CNT_W'(1)); // R7
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full) |=> stat_ovf); // R9
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cur_cont) |=> cs_n == idle_lvl); // R3
endmodule

bind qspi_engine qspi_engine_chk #(.CNT_W(CNT_W), .CS_W(qspi_pkg::CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_done(frame_done),
  .cur_cont(cur_cont), .cur_cclr(cur_cclr), .stat_tc(stat_tc), .stat_eoq(stat_eoq),
  .stat_ovf(stat_ovf), .rx_full(rx_full), .frame_count(frame_count), .cs_n(cs_n),
  .idle_lvl(idle_lvl)
);

// File: tb/qspi_engine_test.sv
module qspi_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_wr = 1'b0, pop_rd = 1'b0, ctl_wr = 1'b0, stat_wr = 1'b0;
  logic [31:0] push_word = '0, ctl_word = '0, stat_word = '0;
  logic        ien_done = 1'b0, ien_eoq = 1'b0, tick = 1'b0, miso_r = 1'b0;
  logic        push_full, pop_empty, irq, sck, mosi;
  logic [15:0] pop_data, frame_count;
  logic [31:0] status;
  logic [5:0]  cs_n;
  logic [27:0] cfg_attr;

  int nchk = 0, nbad = 0;

  // attribute sets: length, cpol, cpha, lsb-first
  int s_len  [4] = '{8, 16, 4, 12};
  bit s_cpol [4] = '{0, 1, 0, 1};
  bit s_cpha [4] = '{0, 1, 1, 0};
  bit s_lsb  [4] = '{0, 1, 0, 1};

  typedef struct { int set; logic [15:0] tx; logic [15:0] sl; bit cclr; } fr_t;
  fr_t         fq[$];
  logic [15:0] rxq[$];
  bit          exp_ovf = 0;
  logic [15:0] exp_cnt = 0;

  always #2 clk = ~clk;

  always_comb
    for (int g = 0; g < 4; g++)
      cfg_attr[g*7 +: 7] = {s_lsb[g], s_cpha[g], s_cpol[g], 4'(s_len[g] - 1)};

  qspi_engine uut (
    .clk(clk), .rst_n(rst_n), .push_wr(push_wr), .push_word(push_word), .push_full(push_full),
    .pop_rd(pop_rd), .pop_data(pop_data), .pop_empty(pop_empty), .ctl_wr(ctl_wr),
    .ctl_word(ctl_word), .stat_wr(stat_wr), .stat_word(stat_word), .status(status),
    .ien_done(ien_done), .ien_eoq(ien_eoq), .irq(irq), .cfg_attr(cfg_attr),
    .frame_count(frame_count), .tick(tick), .sck(sck), .mosi(mosi), .miso(miso_r), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Tick strobe every other cycle
  always @(negedge clk) tick <= ~tick;

  // Serial monitor: follows sck, checks mosi, drives miso, feeds rx model
  int   e_cnt = 0, k_cnt = 0;
  logic sck_prev = 1'b0;
  logic [15:0] got_seq;
  always @(negedge clk) begin
    if (!rst_n) begin
      e_cnt = 0; k_cnt = 0; sck_prev = sck;
    end else begin
      if (sck !== sck_prev) begin
        if (fq.size() == 0) begin
          chk(0, "R8 unexpected serial activity", 1, 0);
        end else begin
          fr_t f; int n; bit cp, ph, lb;
          f = fq[0]; n = s_len[f.set]; cp = s_cpol[f.set]; ph = s_cpha[f.set]; lb = s_lsb[f.set];
          if (!(e_cnt == 0 && sck == cp)) begin
            e_cnt++;
            if ((e_cnt % 2 == 1) != ph) begin
              got_seq[k_cnt] = mosi;
              k_cnt++;
            end
            if (e_cnt == 2 * n) begin
              logic [15:0] exp_seq; logic [15:0] msk;
              exp_seq = '0;
              for (int j = 0; j < n; j++) exp_seq[j] = lb ? f.tx[j] : f.tx[n-1-j];
              msk = 16'((32'h1 << n) - 1);
              chk((got_seq & msk) == exp_seq, "R2 wire bits", got_seq & msk, exp_seq);
              if (rxq.size() < 4) rxq.push_back(f.sl & msk);
              else exp_ovf = 1;
              exp_cnt = (f.cclr ? 16'd0 : exp_cnt) + 16'd1;
              fq.pop_front();
              e_cnt = 0; k_cnt = 0;
            end
          end
        end
      end
      sck_prev = sck;
      if (fq.size() > 0) begin
        int n;
        n = s_len[fq[0].set];
        if (k_cnt < n) miso_r = s_lsb[fq[0].set] ? fq[0].sl[k_cnt] : fq[0].sl[n-1-k_cnt];
      end else miso_r = 1'b0;
    end
  end

  task automatic push_cmd(input int set, input logic [5:0] cs, input bit cont, input bit eoq,
                          input bit cclr, input logic [15:0] d, input logic [15:0] sl, input bit track);
    fr_t f;
    f.set = set; f.tx = d; f.sl = sl; f.cclr = cclr;
    @(negedge clk);
    if (track) fq.push_back(f);
    push_wr = 1'b1;
    push_word = {cont, 1'b0, 2'(set), eoq, cclr, 4'h0, cs, d};
    @(negedge clk);
    push_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic [31:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_word = w;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic w1c(input logic [31:0] w);
    @(negedge clk); stat_wr = 1'b1; stat_word = w;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic pop_check(input string tag);
    logic [15:0] e;
    while (pop_empty) @(negedge clk);
    e = (rxq.size() > 0) ? rxq.pop_front() : 16'hxxxx;
    chk(pop_data === e, tag, pop_data, e);
    pop_rd = 1'b1; @(negedge clk); pop_rd = 1'b0;
  endtask

  task automatic drain();
    while (fq.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic wait_eoq();
    while (!status[28]) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(cs_n == 6'h3F, "R12 cs_n", cs_n, 6'h3F);
    chk(status == 0, "R12 status", status, 0);
    chk(irq == 0, "R12 irq", irq, 0);
    chk(frame_count == 0, "R12 count", frame_count, 0);
    chk(pop_empty == 1, "R12 pop_empty", pop_empty, 1);
    chk(push_full == 0, "R12 push_full", push_full, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R6: one frame per attribute set
    push_cmd(0, 6'b000001, 0, 0, 0, 16'h00A5, 16'h003C, 1);
    while (cs_n == 6'h3F) @(negedge clk);
    chk(cs_n == (6'h3F ^ 6'b000001), "R1 cs mask field", cs_n, 6'h3F ^ 6'b000001);
    push_cmd(1, 6'b000010, 0, 0, 0, 16'hC3E1, 16'h5A96, 1);
    push_cmd(2, 6'b001000, 0, 0, 0, 16'h0009, 16'hFFFF, 1);
    push_cmd(3, 6'b010000, 0, 0, 0, 16'h0B2D, 16'hF6C3, 1);
    drain();
    chk(cs_n == 6'h3F, "R3 released after frame", cs_n, 6'h3F);
    for (int i = 0; i < 4; i++) pop_check("R6 rx data");
    chk(pop_empty == 1, "R6 queue empty", pop_empty, 1);
    chk(frame_count == exp_cnt, "R7 count", frame_count, exp_cnt);

    // R5 transfer-complete flag and clear
    chk(status[31] == 1, "R5 done flag", status[31], 1);
    w1c(32'h1000_0000);
    chk(status[31] == 1, "R5 other bit write keeps flag", status[31], 1);
    w1c(32'h8000_0000);
    chk(status[31] == 0, "R5 cleared", status[31], 0);

    // R11 interrupt
    ien_done = 1'b1;
    chk(irq == 0, "R11 irq low", irq, 0);
    push_cmd(0, 6'b000001, 0, 0, 0, 16'h0055, 16'h0011, 1);
    drain();
    chk(irq == 1, "R11 irq on done", irq, 1);
    ien_done = 1'b0;
    @(negedge clk);
    chk(irq == 0, "R11 irq masked", irq, 0);
    w1c(32'h8000_0000);
    pop_check("R6 rx data");

    // R3 continuous select
    push_cmd(2, 6'b000100, 1, 0, 0, 16'h0006, 16'h0003, 1);
    drain();
    chk(cs_n == (6'h3F ^ 6'b000100), "R3 held", cs_n, 6'h3F ^ 6'b000100);
    push_cmd(2, 6'b000100, 0, 0, 0, 16'h000A, 16'h0005, 1);
    drain();
    chk(cs_n == 6'h3F, "R3 released", cs_n, 6'h3F);
    pop_check("R6 rx data"); pop_check("R6 rx data");

    // R10 idle level
    ctl_write(32'h000F_0000);
    chk(cs_n == 6'h0F, "R10 idle level", cs_n, 6'h0F);
    push_cmd(0, 6'b100000, 1, 0, 0, 16'h00F0, 16'h000F, 1);
    drain();
    chk(cs_n == 6'h2F, "R10 active against idle", cs_n, 6'h2F);
    ctl_write(32'h003F_0000);
    chk(cs_n == 6'h1F, "R10 idle change keeps active", cs_n, 6'h1F);
    push_cmd(0, 6'b100000, 0, 0, 0, 16'h0081, 16'h007E, 1);
    drain();
    chk(cs_n == 6'h3F, "R3 released", cs_n, 6'h3F);
    pop_check("R6 rx data"); pop_check("R6 rx data");

    // R7 counter clear
    push_cmd(1, 6'b000001, 0, 0, 1, 16'h1234, 16'h4321, 1);
    drain();
    chk(frame_count == 1, "R7 clear then count", frame_count, 1);
    push_cmd(3, 6'b000001, 0, 0, 0, 16'h0ABC, 16'h0CBA, 1);
    drain();
    chk(frame_count == 2, "R7 increment", frame_count, 2);
    pop_check("R6 rx data"); pop_check("R6 rx data");

    // R4 end of queue halts
    ien_eoq = 1'b1;
    push_cmd(0, 6'b000001, 0, 1, 0, 16'h003C, 16'h00C3, 1);
    push_cmd(0, 6'b000001, 0, 0, 0, 16'h0066, 16'h0099, 1);
    wait_eoq();
    repeat (40) @(negedge clk);
    chk(fq.size() == 1, "R4 next command held", fq.size(), 1);
    chk(frame_count == 3, "R4 count stopped", frame_count, 3);
    chk(irq == 1, "R11 irq on eoq", irq, 1);
    w1c(32'h1000_0000);
    drain();
    chk(frame_count == 4, "R4 resumed", frame_count, 4);
    chk(status[28] == 0, "R4 flag clear", status[28], 0);
    ien_eoq = 1'b0;
    pop_check("R6 rx data"); pop_check("R6 rx data");

    // R8 full queue and R9 overflow
    push_cmd(2, 6'b000001, 0, 1, 0, 16'h0001, 16'h0002, 1);
    wait_eoq();
    for (int i = 0; i < 4; i++) push_cmd(i, 6'b000010, 0, 0, 0, 16'(16'h0F00 + i*17), 16'(16'h5555 - i*3), 1);
    chk(push_full == 1, "R8 full", push_full, 1);
    push_cmd(0, 6'b000010, 0, 0, 0, 16'h00FF, 16'h00FF, 0);
    w1c(32'h1000_0000);
    drain();
    chk(frame_count == 9, "R8 extra push ignored", frame_count, 9);
    chk(status[19] == exp_ovf, "R9 overflow flag", status[19], exp_ovf);
    for (int i = 0; i < 4; i++) pop_check("R9 kept data");
    chk(pop_empty == 1, "R9 dropped frame", pop_empty, 1);
    w1c(32'h0008_0000);
    chk(status[19] == 0, "R5 overflow cleared", status[19], 0);

    // R10 flushes
    push_cmd(0, 6'b000001, 0, 1, 0, 16'h0042, 16'h0024, 1);
    wait_eoq();
    push_cmd(0, 6'b000001, 0, 0, 0, 16'h0011, 16'h0022, 0);
    push_cmd(0, 6'b000001, 0, 0, 0, 16'h0033, 16'h0044, 0);
    ctl_write(32'h003F_0800);
    w1c(32'h1000_0000);
    repeat (200) @(negedge clk);
    chk(frame_count == 10, "R10 tx flushed", frame_count, 10);
    chk(pop_empty == 0, "R10 rx holds entry", pop_empty, 0);
    ctl_write(32'h003F_0400);
    rxq.delete();
    chk(pop_empty == 1, "R10 rx flushed", pop_empty, 1);

    finish_run();
  end
endmodule